// File: doc/BRIEF.md
# Serial Converter Port Sequencer

This block is the digital front end of a four-channel, 10-bit successive-approximation converter. It watches an active-low chip select, a serial clock and a serial data input, all sampled in the system clock domain. It skips leading zeros, recognises the start bit and collects the rest of an 8-bit control byte, then decodes the channel, polarity, input mode and clock/power mode. From that it times the track/hold window, drives the strobe, and shifts the conversion result out MSB first on falling serial-clock edges.

The analog core is outside the block. It presents a 10-bit offset-binary code and two sub-bits on a parallel port. For internal-clock conversions it also returns a one-cycle done pulse after the block has raised a conversion request. The tri-stated pins are modelled as a data signal plus a separate output-enable, so the block maps onto ordinary pads.

Top module: `adc_ser_port`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on each rising `sclk` edge. Any number of leading 0 bits has no effect, and the first 1 is taken as the start bit, the most significant of eight control bits.
- R2: The seven bits after the start bit are, in arrival order: channel bits 2..0, unipolar flag (1 = unipolar), single-ended flag (1 = single-ended), mode bit 1, mode bit 0. On the falling `sclk` edge after the eighth bit, `sel_chan`, `sel_unipolar` and `sel_single` take the new values.
- R3: Mode 00 and mode 01 are power-down selections. Either one sets `pwrdn` at the falling edge after the eighth bit, and the next falling edge of `cs_n` clears it.
- R4: `track` rises on the falling `sclk` edge after the fifth control bit. It falls (hold) on the falling edge after the eighth bit, and it is low whenever `cs_n` is high.
- R5: In mode 11 (external clock), `strb` is high from the hold edge to the next falling `sclk` edge, and `dout` is 0 at the hold edge. The next 10 falling edges give the result MSB first, then the two sub-bits (bit 1 first), then zeros.
- R6: In mode 10 (internal clock), the hold edge pulses `conv_req` for one clock and drives `strb` low. `strb` goes high when `core_done` arrives, and the result MSB appears on the first falling `sclk` edge after that, followed by the rest as in R5.
- R7: While `cs_n` is high, `dout_oe` is low and `din` is ignored. `strb_oe` is low unless the last accepted control byte selected mode 10, in which case it stays high.
- R8: An internal-clock conversion that has started finishes even if `cs_n` goes high. Its result is still shifted out after `cs_n` returns low.
- R9: With the unipolar flag set, the output word is the core code unchanged. With it clear, the code's MSB is inverted, which turns offset binary into two's complement.
- R10: A start bit that arrives while a result is still being shifted out begins a new control byte. The old result is dropped, and `dout` gives zeros until the new result is loaded.
- R11: `dout` changes only in the clock cycle that detects a falling `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| core_code | input | 10 | Offset-binary result from the analog core |
| core_sub | input | 2 | Sub-bits from the analog core |
| core_done | input | 1 | One-cycle pulse: internal-clock conversion finished |
| conv_req | output | 1 | One-cycle request to start an internal-clock conversion |
| track | output | 1 | 1 = track, 0 = hold |
| sel_chan | output | 3 | Decoded channel select field |
| sel_unipolar | output | 1 | Decoded polarity flag |
| sel_single | output | 1 | Decoded single-ended flag |
| pwrdn | output | 1 | Power-down selected |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |
| strb | output | 1 | Strobe |
| strb_oe | output | 1 | Output enable for strb |

## Verification
The bench sweeps the external-clock sequence over many codes, sub-bit patterns, channel fields, both polarities and zero to three leading zeros. It checks every falling edge: a start-bit detector that counted a leading zero would shift the whole byte and corrupt the decoded fields, and a polarity mix-up would show up as a wrong first data bit. The internal-clock run raises chip select before the done pulse arrives, so a design that aborted on chip select, or floated the strobe, would lose the strobe rise or the data. A restart in the middle of the data shows whether stale result bits leak out after a new start bit. Control bits clocked while chip select is high show whether an ungated input accepts a power-down byte.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        PM_FULL_OFF = 2'b00,
        PM_FAST_OFF = 2'b01,
        PM_INT_CLK  = 2'b10,
        PM_EXT_CLK  = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        pmode_e     pmode;
    } ctrl_cfg_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EXT_STRB,
        SQ_EXT_OUT,
        SQ_INT_CONV,
        SQ_INT_OUT
    } seq_state_e;

    // body bits are the seven bits that follow the start bit, oldest in bit 6
    function automatic ctrl_cfg_t decode_ctrl(input logic [CTRL_W-2:0] body);
        ctrl_cfg_t c;
        c.chan     = body[6:4];
        c.unipolar = body[3];
        c.single   = body[2];
        c.pmode    = pmode_e'(body[1:0]);
        return c;
    endfunction

    function automatic logic is_powerdown(input pmode_e m);
        return (m == PM_FULL_OFF) || (m == PM_FAST_OFF);
    endfunction

endpackage

// File: rtl/adc_ser_edges.sv
module adc_ser_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // serial clock edges only count while the port is selected
    assign sclk_rise = ~cs_n & sclk & ~sclk_q;
    assign sclk_fall = ~cs_n & ~sclk & sclk_q;
    assign cs_fall   = ~cs_n & cs_q;
    assign cs_rise   = cs_n & ~cs_q;
endmodule

// File: rtl/adc_ser_ctrl_cap.sv
module adc_ser_ctrl_cap #(
    parameter int CTRL_W   = 8,
    parameter int TRACK_AT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic              allow_start,
    output logic              start_det,
    output logic              byte_done,
    output logic [CTRL_W-2:0] ctrl_body,
    output logic              track
);
    localparam int CNT_W = $clog2(CTRL_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(CTRL_W);
    localparam logic [CNT_W-1:0] CNT_TRACK = CNT_W'(TRACK_AT);

    logic [CNT_W-1:0]  cnt;
    logic [CTRL_W-2:0] body_q;

    assign start_det = sclk_rise && (cnt == '0) && allow_start && din;
    assign byte_done = sclk_fall && (cnt == CNT_FULL);
    assign ctrl_body = body_q;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            cnt    <= '0;
            body_q <= '0;
            track  <= 1'b0;
        end else begin
            if (start_det) begin
                cnt    <= CNT_W'(1);
                body_q <= '0;
            end else if (sclk_rise && (cnt != '0) && (cnt < CNT_FULL)) begin
                body_q <= {body_q[CTRL_W-3:0], din};
                cnt    <= cnt + 1'b1;
            end
            if (sclk_fall && (cnt == CNT_TRACK)) begin
                track <= 1'b1;
            end
            if (byte_done) begin
                track <= 1'b0;
                cnt   <= '0;
            end
        end
    end
endmodule

// File: rtl/adc_ser_out_shift.sv
module adc_ser_out_shift #(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [OUT_W-1:0] load_val,
    input  logic             sclk_fall,
    output logic             dout
);
    logic [OUT_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            dout <= 1'b0;
        end else if (clear) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
            if (sclk_fall) begin
                dout <= 1'b0;
            end
        end else if (sclk_fall) begin
            dout <= sreg[OUT_W-1];
            sreg <= {sreg[OUT_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_ser_port.sv
module adc_ser_port #(
    parameter int RES_W    = 10,
    parameter int SUB_W    = 2,
    parameter int TRACK_AT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] core_code,
    input  logic [SUB_W-1:0] core_sub,
    input  logic             core_done,
    output logic             conv_req,
    output logic             track,
    output logic [2:0]       sel_chan,
    output logic             sel_unipolar,
    output logic             sel_single,
    output logic             pwrdn,
    output logic             dout,
    output logic             dout_oe,
    output logic             strb,
    output logic             strb_oe
);
    import adc_ser_pkg::*;

    localparam int OUT_W = RES_W + SUB_W;
    localparam logic [RES_W-1:0] SIGN_FLIP = RES_W'(1) << (RES_W - 1);

    logic sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic start_det, byte_done, allow_start;
    logic [CTRL_W-2:0] ctrl_body;
    ctrl_cfg_t cfg_new, cfg_q;
    seq_state_e state;
    logic int_mode;
    logic ext_load, int_load, sh_load;
    logic [OUT_W-1:0] load_val;

    function automatic logic [RES_W-1:0] fmt_code(input logic [RES_W-1:0] c, input logic uni);
        return uni ? c : (c ^ SIGN_FLIP);
    endfunction

    adc_ser_edges edges_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    adc_ser_ctrl_cap #(.CTRL_W(CTRL_W), .TRACK_AT(TRACK_AT)) cap_i (
        .clk(clk), .rst(rst), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din),
        .allow_start(allow_start), .start_det(start_det),
        .byte_done(byte_done), .ctrl_body(ctrl_body), .track(track)
    );

    assign cfg_new     = decode_ctrl(ctrl_body);
    assign allow_start = (state != SQ_INT_CONV);
    assign ext_load    = byte_done && (cfg_new.pmode == PM_EXT_CLK);
    assign int_load    = (state == SQ_INT_CONV) && core_done;
    assign sh_load     = ext_load || int_load;
    assign load_val    = ext_load ? {fmt_code(core_code, cfg_new.unipolar), core_sub}
                                  : {fmt_code(core_code, cfg_q.unipolar), core_sub};

    adc_ser_out_shift #(.OUT_W(OUT_W)) shift_i (
        .clk(clk), .rst(rst), .clear(start_det), .load(sh_load),
        .load_val(load_val), .sclk_fall(sclk_fall), .dout(dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            strb     <= 1'b0;
            int_mode <= 1'b0;
            pwrdn    <= 1'b0;
            conv_req <= 1'b0;
            cfg_q    <= '0;
        end else begin
            conv_req <= 1'b0;
            if (cs_fall) begin
                pwrdn <= 1'b0;
            end
            case (state)
                SQ_EXT_STRB: if (sclk_fall) begin
                    strb  <= 1'b0;
                    state <= SQ_EXT_OUT;
                end
                SQ_INT_CONV: if (core_done) begin
                    strb  <= 1'b1;
                    state <= SQ_INT_OUT;
                end
                default: ;
            endcase
            if (cs_rise && (state == SQ_EXT_STRB || state == SQ_EXT_OUT)) begin
                state <= SQ_IDLE;
                strb  <= 1'b0;
            end
            if (byte_done) begin
                cfg_q <= cfg_new;
                if (cfg_new.pmode == PM_EXT_CLK) begin
                    state    <= SQ_EXT_STRB;
                    strb     <= 1'b1;
                    int_mode <= 1'b0;
                end else if (cfg_new.pmode == PM_INT_CLK) begin
                    state    <= SQ_INT_CONV;
                    strb     <= 1'b0;
                    conv_req <= 1'b1;
                    int_mode <= 1'b1;
                end else begin
                    state    <= SQ_IDLE;
                    strb     <= 1'b0;
                    int_mode <= 1'b0;
                    pwrdn    <= is_powerdown(cfg_new.pmode);
                end
            end
        end
    end

    assign sel_chan     = cfg_q.chan;
    assign sel_unipolar = cfg_q.unipolar;
    assign sel_single   = cfg_q.single;
    assign dout_oe      = ~cs_n;
    assign strb_oe      = int_mode | ~cs_n;
endmodule

// File: rtl/adc_ser_port_chk.sv
module adc_ser_port_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic conv_req,
    input logic track,
    input logic strb,
    input logic dout,
    input logic pwrdn,
    input logic sclk_fall,
    input logic cs_fall
);
    AST_REQ_IN_HOLD: assert property (@(posedge clk) disable iff (rst) conv_req |-> !track); // R4
    AST_TRACK_DESELECT: assert property (@(posedge clk) disable iff (rst) cs_n |=> !track); // R4
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) conv_req |=> !conv_req); // R6
    AST_STRB_LOW_ON_REQ: assert property (@(posedge clk) disable iff (rst) conv_req |-> !strb); // R6
    AST_PWRDN_CLEARED: assert property (@(posedge clk) disable iff (rst) cs_fall |=> !pwrdn); // R3
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst) !sclk_fall |=> $stable(dout)); // R11
endmodule

bind adc_ser_port adc_ser_port_chk chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_req(conv_req), .track(track),
    .strb(strb), .dout(dout), .pwrdn(pwrdn), .sclk_fall(sclk_fall), .cs_fall(cs_fall)
);

// File: tb/adc_ser_port_tb.sv
module adc_ser_port_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, core_done = 1'b0;
    logic [9:0] core_code = '0;
    logic [1:0] core_sub = '0;
    logic conv_req, track, sel_unipolar, sel_single, pwrdn, dout, dout_oe, strb, strb_oe;
    logic [2:0] sel_chan;
    int checks = 0, errors = 0, convs = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_ser_port dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .core_code(core_code), .core_sub(core_sub), .core_done(core_done),
        .conv_req(conv_req), .track(track), .sel_chan(sel_chan),
        .sel_unipolar(sel_unipolar), .sel_single(sel_single), .pwrdn(pwrdn),
        .dout(dout), .dout_oe(dout_oe), .strb(strb), .strb_oe(strb_oe)
    );

    always @(posedge clk) if (!rst && conv_req) convs++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sbit(input logic d);
        @(negedge clk); din = d; sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [11:0] exp_word(input logic [9:0] c, input logic [1:0] s, input logic uni);
        return {uni ? c : (c ^ 10'h200), s};
    endfunction

    // leading zeros, then eight control bits with a track check after each (R4)
    task automatic send_ctrl(input logic [7:0] b, input int lead);
        for (int z = 0; z < lead; z++) sbit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            sbit(b[i]);
            chk("R4 track window", int'(track), int'((8 - i) >= 5 && (8 - i) < 8));
        end
    endtask

    task automatic shift_check(input logic [11:0] w, input int n, input string req);
        for (int m = 0; m < n; m++) begin
            sbit(1'b0);
            chk(req, int'(dout), int'(m < 12 ? w[11 - m] : 1'b0));
        end
    endtask

    task automatic run_ext(input logic [9:0] c, input logic [1:0] s, input logic [2:0] ch,
                           input logic uni, input logic sgl, input int lead);
        core_code = c; core_sub = s;
        @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
        send_ctrl({1'b1, ch, uni, sgl, 2'b11}, lead);
        chk("R1 R2 sel_chan", int'(sel_chan), int'(ch));
        chk("R2 sel_unipolar", int'(sel_unipolar), int'(uni));
        chk("R2 sel_single", int'(sel_single), int'(sgl));
        chk("R5 strb at hold", int'(strb), 1);
        chk("R5 dout at hold", int'(dout), 0);
        chk("R7 dout_oe selected", int'(dout_oe), 1);
        sbit(1'b0);
        chk("R5 strb one period", int'(strb), 0);
        chk(uni ? "R5 msb" : "R9 msb", int'(dout), int'(exp_word(c, s, uni)[11]));
        for (int m = 1; m < 16; m++) begin
            sbit(1'b0);
            chk(uni ? "R5 data bit" : "R9 data bit", int'(dout),
                int'(m < 12 ? exp_word(c, s, uni)[11 - m] : 1'b0));
        end
        @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
        chk("R7 dout_oe deselected", int'(dout_oe), 0);
        chk("R7 strb_oe ext deselected", int'(strb_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 reset dout_oe", int'(dout_oe), 0);
        chk("R7 reset strb_oe", int'(strb_oe), 0);
        chk("R6 reset strb", int'(strb), 0);
        chk("R3 reset pwrdn", int'(pwrdn), 0);
        chk("R4 reset track", int'(track), 0);

        // external-clock sweep
        for (int i = 0; i < 16; i++) begin
            case (i)
                0: c = 10'h000;
                1: c = 10'h3FF;
                2: c = 10'h200;
                3: c = 10'h1FF;
                default: c = 10'((i * 173 + 5) % 1024);
            endcase
            run_ext(c, 2'(i % 4), 3'(i % 8), i[0], i[1], i % 4);
        end

        // control bits clocked while deselected are ignored (R7)
        for (int i = 7; i >= 0; i--) sbit(i == 7 || i == 5);
        chk("R7 din ignored pwrdn", int'(pwrdn), 0);
        chk("R7 din ignored chan", int'(sel_chan), 7);

        // power-down selections (R3)
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
            send_ctrl({1'b1, 3'b010, 1'b1, 1'b1, 1'b0, k[0]}, k);
            chk("R3 pwrdn set", int'(pwrdn), 1);
            chk("R2 chan on pd", int'(sel_chan), 2);
            @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
            chk("R3 pwrdn held deselected", int'(pwrdn), 1);
            cs_n = 1'b0; repeat (2) @(negedge clk);
            chk("R3 pwrdn cleared", int'(pwrdn), 0);
            cs_n = 1'b1; repeat (2) @(negedge clk);
        end

        // internal-clock conversion across a deselect (R6, R8)
        for (int k = 0; k < 2; k++) begin
            core_done = 1'b0;
            @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
            send_ctrl({1'b1, 3'b101, k[0], 1'b1, 2'b10}, 2);
            chk("R6 strb low in conversion", int'(strb), 0);
            chk("R6 one request", convs, k + 1);
            @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
            chk("R7 strb_oe int deselected", int'(strb_oe), 1);
            chk("R7 dout_oe int deselected", int'(dout_oe), 0);
            chk("R8 still converting", int'(strb), 0);
            core_code = k ? 10'h0A5 : 10'h2C3; core_sub = 2'b10;
            repeat (5) @(negedge clk);
            core_done = 1'b1; @(negedge clk); core_done = 1'b0;
            repeat (2) @(negedge clk);
            chk("R6 R8 strb after done", int'(strb), 1);
            cs_n = 1'b0; repeat (2) @(negedge clk);
            shift_check(exp_word(core_code, core_sub, k[0]), 14, "R6 R8 R9 int data");
            @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
        end

        // restart while the result is shifting out (R10)
        core_code = 10'h3C7; core_sub = 2'b11;
        @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
        send_ctrl({1'b1, 3'b001, 1'b1, 1'b0, 2'b11}, 0);
        shift_check(exp_word(10'h3C7, 2'b11, 1'b1), 4, "R5 before restart");
        core_code = 10'h0F0; core_sub = 2'b01;
        begin
            logic [7:0] nb;
            nb = {1'b1, 3'b110, 1'b1, 1'b1, 2'b11};
            for (int i = 7; i >= 0; i--) begin
                sbit(nb[i]);
                chk("R10 old result dropped", int'(dout), 0);
            end
        end
        chk("R10 new byte taken", int'(sel_chan), 6);
        shift_check(exp_word(10'h0F0, 2'b01, 1'b1), 14, "R10 new result");
        @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule